// File: doc/BRIEF.md
# Frame-Slot Operand Rendezvous Unit

This block pairs the two operands of a dyadic instruction without any associative search. Each incoming token names a frame base, an instruction address, an operand side (left or right) and a data value. The unit looks up the instruction word at that address. The word gives an operation code, a slot offset inside the frame and two branch displacements. The rendezvous slot is the frame base plus that offset. A single presence bit on the slot decides what happens. If the bit is clear, the value is parked there. If the bit is set, the parked value is taken, the bit is cleared, and an issue packet is sent out.

The issue packet holds the operation code, both operands in left/right order, the frame base and two successor instruction addresses. Each successor address is the current address plus one displacement. Because every loop iteration owns a separate frame, tokens from different iterations land in different slots and cannot pair by mistake. Instructions flagged as single-input are issued straight away and do not touch the frame.

The unit has two load ports. One writes the instruction store. The other writes a frame slot, both its value and its presence bit. Tokens flow through a two-stage pipeline at one token per cycle. When two tokens hit the same slot on back-to-back cycles, the second one sees the first one's update through forwarding.

Top module: `frame_match_unit`

## Requirements
- R1: After reset, `out_valid` is low and every slot is empty, so the first token to any slot is parked and produces no output.
- R2: At default widths (17 bits) the instruction word holds, from the most significant bit down: operation code in bits 16:13, single-input flag in bit 12, slot offset in bits 11:8, first displacement in bits 7:4, second displacement in bits 3:0.
- R3: A dyadic token whose slot (frame base + offset) is empty writes its value into the slot, marks the slot full, and issues nothing.
- R4: A dyadic token whose slot is full issues a packet with both operands and leaves the slot empty, so the next token for that slot is parked again.
- R5: `tok_port` = 0 marks a left operand and 1 marks a right operand; the issued pair is always presented as (left, right), whichever token came first.
- R6: `out_dest0` = IP + first displacement and `out_dest1` = IP + second displacement, both modulo 2^IP_W; `out_fp` equals the token's frame base.
- R7: `out_opcode` equals the operation code of the instruction named by the token.
- R8: A single-input token issues at once with `out_left` = its value and `out_right` = 0, and does not change the contents of any slot.
- R9: Tokens for the same instruction under different frame bases use different slots and never pair with each other.
- R10: A token accepted at a clock edge produces its packet on the second rising edge after that edge, and not on the first; one token is accepted every cycle.
- R11: When tokens for the same slot arrive on consecutive cycles, the second one sees the slot state left by the first (park then fire, or fire then park).
- R12: The frame load port sets a slot's value and presence bit directly, so a token arriving at a slot preloaded as full fires against the loaded value.
- R13: The slot address is (frame base + offset) modulo 2^SLOT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_fp | input | SLOT_W | Frame base of the token |
| tok_ip | input | IP_W | Instruction address of the token |
| tok_port | input | 1 | Operand side: 0 left, 1 right |
| tok_value | input | VAL_W | Operand value |
| im_load_en | input | 1 | Write the instruction store |
| im_load_addr | input | IP_W | Instruction store write address |
| im_load_word | input | INSTR_W | Instruction word to write |
| fr_load_en | input | 1 | Write a frame slot |
| fr_load_slot | input | SLOT_W | Frame slot to write |
| fr_load_full | input | 1 | Presence bit to write |
| fr_load_value | input | VAL_W | Value to write |
| out_valid | output | 1 | Issue packet valid |
| out_opcode | output | OP_W | Operation code |
| out_fp | output | SLOT_W | Frame base carried to the successors |
| out_left | output | VAL_W | Left operand |
| out_right | output | VAL_W | Right operand (0 for single-input) |
| out_dest0 | output | IP_W | First successor instruction address |
| out_dest1 | output | IP_W | Second successor instruction address |

## Verification
Every result comes out exactly two rising edges after the edge that accepts the token. The first edge registers the instruction fields and the synchronous frame read. The second edge registers the decision and the packet. Each scenario task drives a token just after a falling edge. It samples the outputs at the falling edge after the first rising edge, where `out_valid` must still be low, and again at the falling edge after the second rising edge, where the packet is compared. The back-to-back sequence drives tokens on consecutive falling edges and checks one packet per following falling edge, so forwarded results are checked in the cycle they are due.

// File: rtl/fmu_pkg.sv
// Shared types for the frame-slot rendezvous unit.
// Assumes: nothing beyond IEEE 1800-2017.
package fmu_pkg;

    // What the second pipeline stage does with the token it holds.
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,   // no token in the stage
        ACT_STORE  = 2'd1,   // slot empty: park the value
        ACT_FIRE   = 2'd2,   // slot full: issue the pair, empty the slot
        ACT_BYPASS = 2'd3    // single-input instruction: issue directly
    } fmu_act_e;

endpackage

// File: rtl/fmu_imem.sv
// Instruction store: one write port for loading, one asynchronous read port.
// Assumes: the loader does not rewrite an address while tokens that use it are in flight.
module fmu_imem #(
    parameter int unsigned IP_W    = 5,
    parameter int unsigned INSTR_W = 17
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [IP_W-1:0]    wr_addr,
    input  logic [INSTR_W-1:0] wr_word,
    input  logic [IP_W-1:0]    rd_addr,
    output logic [INSTR_W-1:0] rd_word
);
    localparam int unsigned DEPTH = 1 << IP_W;

    logic [INSTR_W-1:0] mem_q [DEPTH];

    // Load port write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_word;
        end
    end

    // Combinational lookup for the token now arriving.
    always_comb begin
        rd_word = mem_q[rd_addr];
    end
endmodule

// File: rtl/fmu_frame_store.sv
// Frame slots: a value array plus one presence bit per slot.
// Read is synchronous and write-first: a write to the slot being read in the same
// cycle is forwarded to the read register. The presence bits reset to empty; values do not.
// Assumes: a single write port (the caller arbitrates between pipeline and loader).
module fmu_frame_store #(
    parameter int unsigned SLOT_W = 6,
    parameter int unsigned VAL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic              rd_full,
    output logic [VAL_W-1:0]  rd_value,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_full,
    input  logic [VAL_W-1:0]  wr_value
);
    localparam int unsigned DEPTH = 1 << SLOT_W;

    logic [DEPTH-1:0] pres_q;
    logic [VAL_W-1:0] val_q [DEPTH];
    logic             hit_wr;

    // One presence flop per slot, each with its own write decode.
    for (genvar g = 0; g < DEPTH; g++) begin : g_pres
        // Track whether slot g holds a parked operand.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q[g] <= 1'b0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                pres_q[g] <= wr_full;
            end
        end
    end

    // Store slot values.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            val_q[wr_slot] <= wr_value;
        end
    end

    // Detect a same-cycle write to the slot being read.
    always_comb begin
        hit_wr = wr_en && (wr_slot == rd_slot);
    end

    // Registered read with write-first forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_full  <= 1'b0;
            rd_value <= '0;
        end else if (hit_wr) begin
            rd_full  <= wr_full;
            rd_value <= wr_value;
        end else begin
            rd_full  <= pres_q[rd_slot];
            rd_value <= val_q[rd_slot];
        end
    end
endmodule

// File: rtl/fmu_decide.sv
// Second-stage decision: chooses park, fire or bypass from the slot state and
// orders the operands by side. Purely combinational.
// Assumes: slot_full/slot_value already reflect every earlier token (forwarded upstream).
module fmu_decide
    import fmu_pkg::*;
#(
    parameter int unsigned VAL_W = 16
) (
    input  logic             tok_valid,
    input  logic             tok_mono,
    input  logic             tok_port,
    input  logic [VAL_W-1:0] tok_value,
    input  logic             slot_full,
    input  logic [VAL_W-1:0] slot_value,
    output fmu_act_e         act,
    output logic             wr_en,
    output logic             wr_full,
    output logic [VAL_W-1:0] wr_value,
    output logic             issue,
    output logic [VAL_W-1:0] left,
    output logic [VAL_W-1:0] right
);
    // Pick the action for the token in the stage.
    always_comb begin
        if (!tok_valid) begin
            act = ACT_IDLE;
        end else if (tok_mono) begin
            act = ACT_BYPASS;
        end else if (slot_full) begin
            act = ACT_FIRE;
        end else begin
            act = ACT_STORE;
        end
    end

    // Slot update: park sets the bit with the new value, fire clears it.
    always_comb begin
        wr_en    = (act == ACT_STORE) || (act == ACT_FIRE);
        wr_full  = (act == ACT_STORE);
        wr_value = (act == ACT_STORE) ? tok_value : slot_value;
    end

    // Operand ordering: side 0 is left, side 1 is right.
    always_comb begin
        issue = (act == ACT_FIRE) || (act == ACT_BYPASS);
        if (act == ACT_BYPASS) begin
            left  = tok_value;
            right = '0;
        end else if (tok_port) begin
            left  = slot_value;
            right = tok_value;
        end else begin
            left  = tok_value;
            right = slot_value;
        end
    end
endmodule

// File: rtl/frame_match_unit.sv
// Frame-slot operand rendezvous unit (top).
// Stage 1 (edge 1): decode the instruction, form slot = fp + offset, start the
// synchronous frame read, register the token. Stage 2 (edge 2): decide, update
// the slot, register the issue packet.
// Assumes: OFF_W <= SLOT_W and DISP_W <= IP_W; the pipeline's own slot write has
// priority over the frame load port in the same cycle.
module frame_match_unit
    import fmu_pkg::*;
#(
    parameter int unsigned IP_W   = 5,
    parameter int unsigned SLOT_W = 6,
    parameter int unsigned VAL_W  = 16,
    parameter int unsigned OP_W   = 4,
    parameter int unsigned OFF_W  = 4,
    parameter int unsigned DISP_W = 4,
    localparam int unsigned INSTR_W = OP_W + 1 + OFF_W + 2 * DISP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tok_valid,
    input  logic [SLOT_W-1:0]  tok_fp,
    input  logic [IP_W-1:0]    tok_ip,
    input  logic               tok_port,
    input  logic [VAL_W-1:0]   tok_value,
    input  logic               im_load_en,
    input  logic [IP_W-1:0]    im_load_addr,
    input  logic [INSTR_W-1:0] im_load_word,
    input  logic               fr_load_en,
    input  logic [SLOT_W-1:0]  fr_load_slot,
    input  logic               fr_load_full,
    input  logic [VAL_W-1:0]   fr_load_value,
    output logic               out_valid,
    output logic [OP_W-1:0]    out_opcode,
    output logic [SLOT_W-1:0]  out_fp,
    output logic [VAL_W-1:0]   out_left,
    output logic [VAL_W-1:0]   out_right,
    output logic [IP_W-1:0]    out_dest0,
    output logic [IP_W-1:0]    out_dest1
);
    // Field positions inside the instruction word.
    localparam int unsigned D1_LSB   = 0;
    localparam int unsigned D0_LSB   = DISP_W;
    localparam int unsigned OFF_LSB  = 2 * DISP_W;
    localparam int unsigned MONO_BIT = OFF_LSB + OFF_W;
    localparam int unsigned OP_LSB   = MONO_BIT + 1;

    // Stage-1 decode signals.
    logic [INSTR_W-1:0] in_word;
    logic [OP_W-1:0]    in_op;
    logic               in_mono;
    logic [OFF_W-1:0]   in_off;
    logic [DISP_W-1:0]  in_d0;
    logic [DISP_W-1:0]  in_d1;
    logic [SLOT_W-1:0]  in_slot;

    // Stage-2 registers.
    logic               a_valid;
    logic               a_mono;
    logic               a_port;
    logic [VAL_W-1:0]   a_value;
    logic [SLOT_W-1:0]  a_fp;
    logic [SLOT_W-1:0]  a_slot;
    logic [IP_W-1:0]    a_ip;
    logic [OP_W-1:0]    a_op;
    logic [DISP_W-1:0]  a_d0;
    logic [DISP_W-1:0]  a_d1;

    // Frame store interface.
    logic               slot_full;
    logic [VAL_W-1:0]   slot_value;
    logic               fs_wr_en;
    logic [SLOT_W-1:0]  fs_wr_slot;
    logic               fs_wr_full;
    logic [VAL_W-1:0]   fs_wr_value;

    // Decision outputs.
    fmu_act_e           a_act;
    logic               dec_wr_en;
    logic               dec_wr_full;
    logic [VAL_W-1:0]   dec_wr_value;
    logic               dec_issue;
    logic [VAL_W-1:0]   dec_left;
    logic [VAL_W-1:0]   dec_right;

    fmu_imem #(
        .IP_W    (IP_W),
        .INSTR_W (INSTR_W)
    ) u_imem (
        .clk     (clk),
        .wr_en   (im_load_en),
        .wr_addr (im_load_addr),
        .wr_word (im_load_word),
        .rd_addr (tok_ip),
        .rd_word (in_word)
    );

    // Split the instruction word and form the rendezvous slot address.
    always_comb begin
        in_op   = in_word[OP_LSB +: OP_W];
        in_mono = in_word[MONO_BIT];
        in_off  = in_word[OFF_LSB +: OFF_W];
        in_d0   = in_word[D0_LSB +: DISP_W];
        in_d1   = in_word[D1_LSB +: DISP_W];
        in_slot = tok_fp + SLOT_W'(in_off);
    end

    // Stage-1 token register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_mono  <= 1'b0;
            a_port  <= 1'b0;
            a_value <= '0;
            a_fp    <= '0;
            a_slot  <= '0;
            a_ip    <= '0;
            a_op    <= '0;
            a_d0    <= '0;
            a_d1    <= '0;
        end else begin
            a_valid <= tok_valid;
            a_mono  <= in_mono;
            a_port  <= tok_port;
            a_value <= tok_value;
            a_fp    <= tok_fp;
            a_slot  <= in_slot;
            a_ip    <= tok_ip;
            a_op    <= in_op;
            a_d0    <= in_d0;
            a_d1    <= in_d1;
        end
    end

    fmu_decide #(
        .VAL_W (VAL_W)
    ) u_decide (
        .tok_valid  (a_valid),
        .tok_mono   (a_mono),
        .tok_port   (a_port),
        .tok_value  (a_value),
        .slot_full  (slot_full),
        .slot_value (slot_value),
        .act        (a_act),
        .wr_en      (dec_wr_en),
        .wr_full    (dec_wr_full),
        .wr_value   (dec_wr_value),
        .issue      (dec_issue),
        .left       (dec_left),
        .right      (dec_right)
    );

    // Frame write arbitration: pipeline update first, loader otherwise.
    always_comb begin
        if (dec_wr_en) begin
            fs_wr_en    = 1'b1;
            fs_wr_slot  = a_slot;
            fs_wr_full  = dec_wr_full;
            fs_wr_value = dec_wr_value;
        end else begin
            fs_wr_en    = fr_load_en;
            fs_wr_slot  = fr_load_slot;
            fs_wr_full  = fr_load_full;
            fs_wr_value = fr_load_value;
        end
    end

    fmu_frame_store #(
        .SLOT_W (SLOT_W),
        .VAL_W  (VAL_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_slot  (in_slot),
        .rd_full  (slot_full),
        .rd_value (slot_value),
        .wr_en    (fs_wr_en),
        .wr_slot  (fs_wr_slot),
        .wr_full  (fs_wr_full),
        .wr_value (fs_wr_value)
    );

    // Issue packet register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_opcode <= '0;
            out_fp     <= '0;
            out_left   <= '0;
            out_right  <= '0;
            out_dest0  <= '0;
            out_dest1  <= '0;
        end else begin
            out_valid  <= dec_issue;
            out_opcode <= a_op;
            out_fp     <= a_fp;
            out_left   <= dec_left;
            out_right  <= dec_right;
            out_dest0  <= a_ip + IP_W'(a_d0);
            out_dest1  <= a_ip + IP_W'(a_d1);
        end
    end
endmodule

// File: rtl/fmu_checker.sv
// Temporal checks for frame_match_unit, attached by bind below.
// Assumes: connected to the top's clock, reset, token valid, stage-2 action/slot and out_valid.
module fmu_checker
    import fmu_pkg::*;
#(
    parameter int unsigned SLOT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_valid,
    input logic              a_valid,
    input fmu_act_e          a_act,
    input logic [SLOT_W-1:0] a_slot,
    input logic              out_valid
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R10
    out_from_token_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(tok_valid, 2));

    // R3
    store_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_act == ACT_STORE) |=> !out_valid);

    // R4
    fire_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && a_act == ACT_FIRE) |=> out_valid);

    // R8
    bypass_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_act == ACT_BYPASS) |=> out_valid);

    // R11
    fwd_park_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && $past(a_valid) && $past(a_act) == ACT_STORE
         && a_slot == $past(a_slot) && a_act != ACT_BYPASS) |-> (a_act == ACT_FIRE));

    // R11
    fwd_fire_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && $past(a_valid) && $past(a_act) == ACT_FIRE
         && a_slot == $past(a_slot) && a_act != ACT_BYPASS) |-> (a_act == ACT_STORE));
endmodule

bind frame_match_unit fmu_checker #(
    .SLOT_W (SLOT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_valid (tok_valid),
    .a_valid   (a_valid),
    .a_act     (a_act),
    .a_slot    (a_slot),
    .out_valid (out_valid)
);

// File: tb/frame_match_unit_tb.sv
// Directed bench for frame_match_unit: one task per scenario, each checking its own results.
module frame_match_unit_tb;
    localparam int unsigned IP_W = 5, SLOT_W = 6, VAL_W = 16, OP_W = 4;
    localparam int unsigned INSTR_W = 17;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tok_valid = 1'b0;
    logic [SLOT_W-1:0]  tok_fp = '0;
    logic [IP_W-1:0]    tok_ip = '0;
    logic               tok_port = 1'b0;
    logic [VAL_W-1:0]   tok_value = '0;
    logic               im_load_en = 1'b0;
    logic [IP_W-1:0]    im_load_addr = '0;
    logic [INSTR_W-1:0] im_load_word = '0;
    logic               fr_load_en = 1'b0;
    logic [SLOT_W-1:0]  fr_load_slot = '0;
    logic               fr_load_full = 1'b0;
    logic [VAL_W-1:0]   fr_load_value = '0;
    logic               out_valid;
    logic [OP_W-1:0]    out_opcode;
    logic [SLOT_W-1:0]  out_fp;
    logic [VAL_W-1:0]   out_left;
    logic [VAL_W-1:0]   out_right;
    logic [IP_W-1:0]    out_dest0;
    logic [IP_W-1:0]    out_dest1;

    int n_checks = 0;
    int n_fail   = 0;

    frame_match_unit u_dut (
        .clk (clk), .rst_n (rst_n),
        .tok_valid (tok_valid), .tok_fp (tok_fp), .tok_ip (tok_ip),
        .tok_port (tok_port), .tok_value (tok_value),
        .im_load_en (im_load_en), .im_load_addr (im_load_addr), .im_load_word (im_load_word),
        .fr_load_en (fr_load_en), .fr_load_slot (fr_load_slot),
        .fr_load_full (fr_load_full), .fr_load_value (fr_load_value),
        .out_valid (out_valid), .out_opcode (out_opcode), .out_fp (out_fp),
        .out_left (out_left), .out_right (out_right),
        .out_dest0 (out_dest0), .out_dest1 (out_dest1)
    );

    always #10 clk = ~clk;

    // R2 layout: opcode | single-input flag | offset | disp0 | disp1
    function automatic logic [INSTR_W-1:0] mk_word(input logic [3:0] op, input logic mono,
        input logic [3:0] off, input logic [3:0] d0, input logic [3:0] d1);
        return {op, mono, off, d0, d1};
    endfunction

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic check_none(input string req);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%b expected=0", req, out_valid);
        end
    endtask

    task automatic check_pkt(input string req, input logic [3:0] op, input logic [5:0] fp,
        input logic [15:0] l, input logic [15:0] r, input logic [4:0] d0, input logic [4:0] d1);
        n_checks++;
        if (out_valid !== 1'b1 || out_opcode !== op || out_fp !== fp || out_left !== l ||
            out_right !== r || out_dest0 !== d0 || out_dest1 !== d1) begin
            n_fail++;
            $display("FAIL %s actual v=%b op=%0d fp=%0d l=%h r=%h d0=%0d d1=%0d expected v=1 op=%0d fp=%0d l=%h r=%h d0=%0d d1=%0d",
                req, out_valid, out_opcode, out_fp, out_left, out_right, out_dest0, out_dest1,
                op, fp, l, r, d0, d1);
        end
    endtask

    // Present one token for one cycle; called just after a falling edge.
    task automatic drive(input logic [5:0] fp, input logic [4:0] ip, input logic port,
        input logic [15:0] v);
        tok_valid = 1'b1; tok_fp = fp; tok_ip = ip; tok_port = port; tok_value = v;
    endtask

    // Send one token, check nothing is out one edge later, return at the sample point two edges later.
    task automatic send(input string req, input logic [5:0] fp, input logic [4:0] ip,
        input logic port, input logic [15:0] v);
        drive(fp, ip, port, v);
        @(negedge clk);
        tok_valid = 1'b0;
        check_none({req, " R10 early"});
        @(negedge clk);
    endtask

    task automatic load_instr(input logic [4:0] a, input logic [INSTR_W-1:0] w);
        im_load_en = 1'b1; im_load_addr = a; im_load_word = w;
        @(negedge clk);
        im_load_en = 1'b0;
    endtask

    task automatic load_slot(input logic [5:0] s, input logic full, input logic [15:0] v);
        fr_load_en = 1'b1; fr_load_slot = s; fr_load_full = full; fr_load_value = v;
        @(negedge clk);
        fr_load_en = 1'b0;
    endtask

    // R1: quiet after reset.
    task automatic t_reset();
        check_none("R1 reset");
    endtask

    // R1 R3 R4 R5 R6 R7: park then fire, both arrival orders.
    task automatic t_pair();
        send("R1 R3 first", 6'd4, 5'd1, 1'b1, 16'h1111);
        check_none("R3 park");
        send("R4", 6'd4, 5'd1, 1'b0, 16'h2222);
        check_pkt("R4 R5 R6 R7 fire", 4'd3, 6'd4, 16'h2222, 16'h1111, 5'd2, 5'd4);
        send("R4", 6'd4, 5'd1, 1'b0, 16'hAAAA);
        check_none("R4 slot emptied");
        send("R5", 6'd4, 5'd1, 1'b1, 16'hBBBB);
        check_pkt("R5 left first", 4'd3, 6'd4, 16'hAAAA, 16'hBBBB, 5'd2, 5'd4);
    endtask

    // R9: separate frames do not pair.
    task automatic t_frames();
        send("R9", 6'd10, 5'd1, 1'b0, 16'h0010);
        check_none("R9 park frame a");
        send("R9", 6'd20, 5'd1, 1'b0, 16'h0020);
        check_none("R9 park frame b");
        send("R9", 6'd20, 5'd1, 1'b1, 16'h0021);
        check_pkt("R9 fire frame b", 4'd3, 6'd20, 16'h0020, 16'h0021, 5'd2, 5'd4);
        send("R9", 6'd10, 5'd1, 1'b1, 16'h0011);
        check_pkt("R9 fire frame a", 4'd3, 6'd10, 16'h0010, 16'h0011, 5'd2, 5'd4);
    endtask

    // R8: single-input bypass leaves slot 7 untouched.
    task automatic t_mono();
        send("R8", 6'd5, 5'd1, 1'b0, 16'h7070);
        check_none("R8 park slot 7");
        send("R8", 6'd7, 5'd2, 1'b1, 16'h5555);
        check_pkt("R8 bypass", 4'd5, 6'd7, 16'h5555, 16'h0000, 5'd4, 5'd2);
        send("R8", 6'd5, 5'd1, 1'b1, 16'h7171);
        check_pkt("R8 slot intact", 4'd3, 6'd5, 16'h7070, 16'h7171, 5'd2, 5'd4);
    endtask

    // R13 R6: slot and successor addresses wrap.
    task automatic t_wrap();
        send("R13", 6'd60, 5'd31, 1'b0, 16'h0101);
        check_none("R13 park slot 11");
        send("R13", 6'd60, 5'd31, 1'b1, 16'h0202);
        check_pkt("R13 R6 wrap", 4'd9, 6'd60, 16'h0101, 16'h0202, 5'd3, 5'd14);
    endtask

    // R12: preloaded full slot fires on the first token.
    task automatic t_preload();
        load_slot(6'd40, 1'b1, 16'h4444);
        send("R12", 6'd38, 5'd1, 1'b1, 16'h0404);
        check_pkt("R12 preload", 4'd3, 6'd38, 16'h4444, 16'h0404, 5'd2, 5'd4);
    endtask

    // R10 R11: three back-to-back tokens on one slot.
    task automatic t_b2b();
        drive(6'd30, 5'd1, 1'b0, 16'h3000);
        @(negedge clk);
        check_none("R10 nothing after one edge");
        drive(6'd30, 5'd1, 1'b1, 16'h3001);
        @(negedge clk);
        drive(6'd30, 5'd1, 1'b0, 16'h3002);
        check_none("R11 first parks");
        @(negedge clk);
        tok_valid = 1'b0;
        check_pkt("R11 park then fire", 4'd3, 6'd30, 16'h3000, 16'h3001, 5'd2, 5'd4);
        @(negedge clk);
        check_none("R11 fire then park");
        send("R11", 6'd30, 5'd1, 1'b1, 16'h3003);
        check_pkt("R11 later fire", 4'd3, 6'd30, 16'h3002, 16'h3003, 5'd2, 5'd4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_instr(5'd1, mk_word(4'd3, 1'b0, 4'd2, 4'd1, 4'd3));
        load_instr(5'd2, mk_word(4'd5, 1'b1, 4'd0, 4'd2, 4'd0));
        load_instr(5'd31, mk_word(4'd9, 1'b0, 4'd15, 4'd4, 4'd15));
        t_pair();
        t_frames();
        t_mono();
        t_wrap();
        t_preload();
        t_b2b();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule